// File: doc/BRIEF.md
# Low-Power Entry Status Flags

This block holds the two status flags that software inspects after waking from a low-power state. One flag records a stop-style entry taken while the system clock ran from the internal oscillator. The other records a standby entry that ended in a CPU restart from the reset vector. Hardware strobes set the flags. Software clears both at once by writing a one to a command bit in the status word. The command bit itself always reads as zero.

There are two reset inputs. Power-on reset clears everything. System reset clears the stop flag and the access configuration, but it leaves the standby flag and its arming latch alone, so software still sees the standby flag after the restart that system reset causes.

Register accesses carry a secure attribute and a privileged attribute. A low-power security bit and two privilege bits decide which accesses may see the status word and which may clear it. A refused access reads zero, its write has no effect, and no error is raised.

Top module: `lpm_status_flags`

## Requirements
- R1: After power-on reset, every readable word reads zero: the status word at byte offset 56, the security word at 48 and the privilege word at 52.
- R2: A permitted write to offset 56 with data bit 0 set clears the stop flag and the standby flag on the next clock edge. The clear happens only when no set event occurs in the same cycle.
- R3: When a stop entry strobe or a standby entry strobe arrives while the internal-oscillator indication is high, the stop flag is set on the next clock edge. The same strobe with the indication low does not set it.
- R4: A standby entry strobe arms a pending latch. A CPU restart strobe seen while the latch is armed sets the standby flag and disarms the latch. A restart seen while the latch is not armed changes nothing.
- R5: In any cycle where the standby flag becomes set, the stop flag is cleared, even if a stop set event occurs in that same cycle.
- R6: A set event beats a clear write in the same cycle. The flag being set ends up set.
- R7: System reset clears the stop flag, the security bit and both privilege bits. It does not clear the standby flag or the pending latch. Power-on reset clears all of them.
- R8: The low-power security bit is offset 48, bit 12, and only secure writes can change it. While it is 1, a non-secure write to offset 56 is ignored and a non-secure read of offset 56 returns zero.
- R9: Offset 52 holds two privilege bits. Bit 0 applies while the security bit is 1 and only a secure privileged write can change it. Bit 1 applies while the security bit is 0 and any privileged write can change it. When the privilege bit that applies is 1, an unprivileged access to offset 56 reads zero and its clear write is ignored.
- R10: The status word reads back with the stop flag in bit 1, the standby flag in bit 2 and bit 0 as zero. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n_i | input | 1 | System reset, asynchronous, active low |
| stop_enter_i | input | 1 | Strobe: a stop-style low-power state was entered |
| stby_enter_i | input | 1 | Strobe: the standby state was entered |
| sysclk_int_osc_i | input | 1 | High while the system clock is forced onto the internal oscillator |
| cpu_restart_i | input | 1 | Strobe: the CPU restarted from its reset vector |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | DATA_W | Write data |
| wr_secure_i | input | 1 | Write access is secure |
| wr_priv_i | input | 1 | Write access is privileged |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_secure_i | input | 1 | Read access is secure |
| rd_priv_i | input | 1 | Read access is privileged |
| rd_data_o | output | DATA_W | Combinational read data |

## Verification
The bench targets the following corner cases; each has a distinctive symptom if the design gets it wrong:
- **Set event and clear write in the same cycle.** A design with the priority reversed loses a fresh stop or standby record.
- **Stop set and standby set in the same cycle.** A design that forgets the forced stop clear reports both flags together.
- **System reset between standby entry and restart, or after the standby flag is set.** A design that puts the latch or the flag in the wrong reset domain loses the standby record.
- **Security bit and privilege bits in every combination.** A filter that picks the wrong privilege bit, or that checks only security, lets a refused access clear the flags or read them.

// File: rtl/lpm_flag_pkg.sv
package lpm_flag_pkg;

  // Decide whether an access may touch the status word.
  function automatic logic access_ok(input logic sec_cfg, input logic spriv,
                                     input logic nspriv, input logic acc_secure,
                                     input logic acc_priv);
    logic need_priv;
    need_priv = sec_cfg ? spriv : nspriv;
    return (!sec_cfg || acc_secure) && (!need_priv || acc_priv);
  endfunction

  // Next stop flag: standby set forces clear, then set, then software clear.
  function automatic logic next_stop(input logic cur, input logic stby_set,
                                     input logic stop_set, input logic clr);
    if (stby_set)      return 1'b0;
    else if (stop_set) return 1'b1;
    else if (clr)      return 1'b0;
    return cur;
  endfunction

  // Next standby flag: set has priority over software clear.
  function automatic logic next_stby(input logic cur, input logic stby_set,
                                     input logic clr);
    if (stby_set) return 1'b1;
    else if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/lpm_access_filter.sv
module lpm_access_filter #(
  parameter int NPORT = 2
) (
  input  logic             lpm_sec_i,
  input  logic             spriv_i,
  input  logic             nspriv_i,
  input  logic [NPORT-1:0] acc_secure_i,
  input  logic [NPORT-1:0] acc_priv_i,
  output logic [NPORT-1:0] allowed_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign allowed_o[p] = lpm_flag_pkg::access_ok(lpm_sec_i, spriv_i, nspriv_i,
                                                  acc_secure_i[p], acc_priv_i[p]);
  end
endmodule

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sec_we_i,
  input  logic priv_we_i,
  input  logic sec_bit_i,
  input  logic spriv_bit_i,
  input  logic nspriv_bit_i,
  input  logic wr_secure_i,
  input  logic wr_priv_i,
  output logic lpm_sec_o,
  output logic spriv_o,
  output logic nspriv_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lpm_sec_o <= 1'b0;
      spriv_o   <= 1'b0;
      nspriv_o  <= 1'b0;
    end else begin
      if (sec_we_i && wr_secure_i)               lpm_sec_o <= sec_bit_i;
      if (priv_we_i && wr_secure_i && wr_priv_i) spriv_o   <= spriv_bit_i;
      if (priv_we_i && wr_priv_i)                nspriv_o  <= nspriv_bit_i;
    end
  end
endmodule

// File: rtl/lpm_flag_core.sv
module lpm_flag_core (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic sys_n_i,
  input  logic stop_enter_i,
  input  logic stby_enter_i,
  input  logic sysclk_int_osc_i,
  input  logic cpu_restart_i,
  input  logic clr_fire_i,
  output logic stop_flag_o,
  output logic stby_flag_o,
  output logic stop_set_ev_o,
  output logic stby_set_ev_o
);
  logic armed;

  assign stop_set_ev_o = (stop_enter_i || stby_enter_i) && sysclk_int_osc_i;
  assign stby_set_ev_o = cpu_restart_i && armed;

  // Power-on domain: survives system reset.
  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      armed       <= 1'b0;
      stby_flag_o <= 1'b0;
    end else begin
      if (stby_enter_i)       armed <= 1'b1;
      else if (cpu_restart_i) armed <= 1'b0;
      stby_flag_o <= lpm_flag_pkg::next_stby(stby_flag_o, stby_set_ev_o, clr_fire_i);
    end
  end

  // System domain.
  always_ff @(posedge clk_i or negedge sys_n_i) begin
    if (!sys_n_i) stop_flag_o <= 1'b0;
    else stop_flag_o <= lpm_flag_pkg::next_stop(stop_flag_o, stby_set_ev_o,
                                                 stop_set_ev_o, clr_fire_i);
  end
endmodule

// File: rtl/lpm_status_flags.sv
module lpm_status_flags #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SECCFG_OFS  = 48,
  parameter int PRIVCFG_OFS = 52,
  parameter int STATUS_OFS  = 56,
  parameter int LPMSEC_BIT  = 12,
  parameter int CLR_BIT     = 0,
  parameter int STOPF_BIT   = 1,
  parameter int SBF_BIT     = 2,
  parameter int SPRIV_BIT   = 0,
  parameter int NSPRIV_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              sys_rst_n_i,
  input  logic              stop_enter_i,
  input  logic              stby_enter_i,
  input  logic              sysclk_int_osc_i,
  input  logic              cpu_restart_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_secure_i,
  input  logic              wr_priv_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_secure_i,
  input  logic              rd_priv_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(SECCFG_OFS);
  localparam logic [ADDR_W-1:0] A_PRIV = ADDR_W'(PRIVCFG_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_OFS);

  // Named internal events, used by the checker.
  logic sys_any_n;
  logic lpm_sec, spriv, nspriv;
  logic wr_hits_status, wr_hits_sec, wr_hits_priv, rd_hits_status;
  logic wr_allowed, rd_allowed, clr_fire;
  logic stop_flag, stby_flag, stop_set_ev, stby_set_ev;
  logic [1:0] acc_ok;

  assign sys_any_n      = por_n_i && sys_rst_n_i;
  assign wr_hits_status = wr_en_i && (wr_addr_i == A_STAT);
  assign wr_hits_sec    = wr_en_i && (wr_addr_i == A_SEC);
  assign wr_hits_priv   = wr_en_i && (wr_addr_i == A_PRIV);
  assign rd_hits_status = (rd_addr_i == A_STAT);

  lpm_cfg_regs u_cfg (
    .clk_i        (clk_i),
    .rst_n_i      (sys_any_n),
    .sec_we_i     (wr_hits_sec),
    .priv_we_i    (wr_hits_priv),
    .sec_bit_i    (wr_data_i[LPMSEC_BIT]),
    .spriv_bit_i  (wr_data_i[SPRIV_BIT]),
    .nspriv_bit_i (wr_data_i[NSPRIV_BIT]),
    .wr_secure_i  (wr_secure_i),
    .wr_priv_i    (wr_priv_i),
    .lpm_sec_o    (lpm_sec),
    .spriv_o      (spriv),
    .nspriv_o     (nspriv)
  );

  lpm_access_filter #(.NPORT(2)) u_filt (
    .lpm_sec_i    (lpm_sec),
    .spriv_i      (spriv),
    .nspriv_i     (nspriv),
    .acc_secure_i ({rd_secure_i, wr_secure_i}),
    .acc_priv_i   ({rd_priv_i, wr_priv_i}),
    .allowed_o    (acc_ok)
  );

  assign wr_allowed = acc_ok[0];
  assign rd_allowed = acc_ok[1];
  assign clr_fire   = wr_hits_status && wr_allowed && wr_data_i[CLR_BIT];

  lpm_flag_core u_core (
    .clk_i            (clk_i),
    .por_n_i          (por_n_i),
    .sys_n_i          (sys_any_n),
    .stop_enter_i     (stop_enter_i),
    .stby_enter_i     (stby_enter_i),
    .sysclk_int_osc_i (sysclk_int_osc_i),
    .cpu_restart_i    (cpu_restart_i),
    .clr_fire_i       (clr_fire),
    .stop_flag_o      (stop_flag),
    .stby_flag_o      (stby_flag),
    .stop_set_ev_o    (stop_set_ev),
    .stby_set_ev_o    (stby_set_ev)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_hits_status && rd_allowed) begin
      rd_data_o[STOPF_BIT] = stop_flag;
      rd_data_o[SBF_BIT]   = stby_flag;
    end else if (rd_addr_i == A_SEC) begin
      rd_data_o[LPMSEC_BIT] = lpm_sec;
    end else if (rd_addr_i == A_PRIV) begin
      rd_data_o[SPRIV_BIT]  = spriv;
      rd_data_o[NSPRIV_BIT] = nspriv;
    end
  end
endmodule

// File: rtl/lpm_status_flags_chk.sv
module lpm_status_flags_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              por_n_i,
  input logic              sys_rst_n_i,
  input logic              cpu_restart_i,
  input logic              stop_set_ev,
  input logic              stby_set_ev,
  input logic              clr_fire,
  input logic              wr_hits_status,
  input logic              wr_allowed,
  input logic              rd_hits_status,
  input logic              rd_allowed,
  input logic              stop_flag,
  input logic              stby_flag,
  input logic [DATA_W-1:0] rd_data_o
);
  assert_stop_set_R3: assert property (@(posedge clk_i) disable iff (!por_n_i || !sys_rst_n_i)
    stop_set_ev && !stby_set_ev |=> stop_flag);

  assert_stby_set_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    stby_set_ev |=> stby_flag);

  assert_stop_forced_clear_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    stby_set_ev |=> !stop_flag);

  assert_clear_stby_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    clr_fire && !stby_set_ev |=> !stby_flag);

  assert_clear_stop_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    clr_fire && !stop_set_ev |=> !stop_flag);

  assert_refused_write_R8: assert property (@(posedge clk_i) disable iff (!por_n_i || !sys_rst_n_i)
    wr_hits_status && !wr_allowed && !stop_set_ev && !stby_set_ev
      |=> $stable(stop_flag) && $stable(stby_flag));

  assert_stby_survives_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !sys_rst_n_i && !cpu_restart_i && !clr_fire |=> $stable(stby_flag));

  assert_stop_in_sysrst_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !sys_rst_n_i |-> !stop_flag);

  assert_refused_read_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rd_hits_status && !rd_allowed |-> rd_data_o == '0);
endmodule

bind lpm_status_flags lpm_status_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .por_n_i        (por_n_i),
  .sys_rst_n_i    (sys_rst_n_i),
  .cpu_restart_i  (cpu_restart_i),
  .stop_set_ev    (stop_set_ev),
  .stby_set_ev    (stby_set_ev),
  .clr_fire       (clr_fire),
  .wr_hits_status (wr_hits_status),
  .wr_allowed     (wr_allowed),
  .rd_hits_status (rd_hits_status),
  .rd_allowed     (rd_allowed),
  .stop_flag      (stop_flag),
  .stby_flag      (stby_flag),
  .rd_data_o      (rd_data_o)
);

// File: tb/sim_lpm_status_flags.sv
module sim_lpm_status_flags;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n = 1'b0, sys_n = 1'b1;
  logic se = 0, sbe = 0, osc = 0, rst_cpu = 0;
  logic we = 0, ws = 0, wp = 0, rs = 1, rp = 1;
  logic [7:0]  wa = 0, ra = 8'd56;
  logic [31:0] wd = 0;
  logic [31:0] rd;

  int checks = 0, errors = 0;
  string tag = "R1";

  // Model state
  logic m_stop = 0, m_stby = 0, m_arm = 0, m_sec = 0, m_sp = 0, m_np = 0;

  lpm_status_flags u0 (
    .clk_i(clk), .por_n_i(por_n), .sys_rst_n_i(sys_n),
    .stop_enter_i(se), .stby_enter_i(sbe), .sysclk_int_osc_i(osc),
    .cpu_restart_i(rst_cpu), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .wr_secure_i(ws), .wr_priv_i(wp), .rd_addr_i(ra), .rd_secure_i(rs),
    .rd_priv_i(rp), .rd_data_o(rd)
  );

  function automatic logic perm(logic sec, logic sp, logic np, logic a_s, logic a_p);
    case (sec)
      1'b1:    return a_s && (a_p || !sp);
      default: return a_p || !np;
    endcase
  endfunction

  function automatic logic [31:0] exp_read();
    logic [31:0] v = 32'h0;
    if (ra == 8'd56) begin
      if (perm(m_sec, m_sp, m_np, rs, rp)) v = {29'h0, m_stby, m_stop, 1'b0};
    end else if (ra == 8'd48) v[12] = m_sec;
    else if (ra == 8'd52) v[1:0] = {m_np, m_sp};
    return v;
  endfunction

  task automatic apply_resets();
    if (!por_n) begin
      m_stop = 0; m_stby = 0; m_arm = 0; m_sec = 0; m_sp = 0; m_np = 0;
    end else if (!sys_n) begin
      m_stop = 0; m_sec = 0; m_sp = 0; m_np = 0;
    end
  endtask

  // Check current read, advance model, move to next falling edge, idle strobes.
  task automatic tick();
    logic clr, sset, bset, n_sec, n_sp, n_np;
    #1;
    apply_resets();
    checks++;
    if (rd !== exp_read()) begin
      errors++;
      $display("FAIL %s: addr=%0d got=%h exp=%h", tag, ra, rd, exp_read());
    end
    clr  = we && wa == 8'd56 && wd[0] && perm(m_sec, m_sp, m_np, ws, wp);
    bset = rst_cpu && m_arm;
    sset = (se || sbe) && osc;
    n_sec = (we && wa == 8'd48 && ws) ? wd[12] : m_sec;
    n_sp  = (we && wa == 8'd52 && ws && wp) ? wd[0] : m_sp;
    n_np  = (we && wa == 8'd52 && wp) ? wd[1] : m_np;
    if (sbe) m_arm = 1; else if (rst_cpu) m_arm = 0;
    m_stop = bset ? 1'b0 : sset ? 1'b1 : clr ? 1'b0 : m_stop;
    m_stby = bset ? 1'b1 : clr ? 1'b0 : m_stby;
    m_sec = n_sec; m_sp = n_sp; m_np = n_np;
    apply_resets();
    @(negedge clk);
    se = 0; sbe = 0; rst_cpu = 0; we = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic s, input logic p);
    we = 1; wa = a; wd = d; ws = s; wp = p;
  endtask

  task automatic rdset(input logic [7:0] a, input logic s, input logic p);
    ra = a; rs = s; rp = p;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, got=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    // R1: reset state on all words
    tag = "R1"; tick(); rdset(8'd48, 1, 1); tick();
    por_n = 1; rdset(8'd52, 1, 1); tick();
    rdset(8'd56, 1, 1); tick();
    // R3: stop set with and without internal oscillator
    tag = "R3"; se = 1; osc = 1; tick(); tick();
    wr(8'd56, 32'h1, 1, 1); tick();
    se = 1; osc = 0; tick(); tick();
    sbe = 1; osc = 1; tick(); tick();         // arms, sets stop
    // R4: restart when armed sets standby; second restart does nothing new
    tag = "R4"; osc = 0; rst_cpu = 1; tick(); tick();
    tag = "R2"; wr(8'd56, 32'h1, 1, 1); tick(); tick();
    tag = "R4"; rst_cpu = 1; tick(); tick();  // not armed
    // R5: simultaneous stop set and standby set
    tag = "R5"; sbe = 1; tick(); se = 1; osc = 1; rst_cpu = 1; tick(); tick();
    // R6: set beats clear
    tag = "R6"; wr(8'd56, 32'h1, 1, 1); se = 1; osc = 1; tick(); tick();
    sbe = 1; osc = 0; tick(); rst_cpu = 1; wr(8'd56, 32'h1, 1, 1); tick(); tick();
    // R10: read mapping and other offsets
    tag = "R10"; se = 1; osc = 1; tick(); tick(); rdset(8'd60, 1, 1); tick(); rdset(8'd56, 1, 1);
    // R7: system reset keeps standby and armed latch
    tag = "R7"; wr(8'd48, 32'h1000, 1, 1); tick(); sbe = 1; osc = 0; tick();
    sys_n = 0; tick(); tick(); sys_n = 1; tick();
    rdset(8'd48, 1, 1); tick(); rdset(8'd56, 1, 1);
    wr(8'd56, 32'h1, 1, 1); tick(); rst_cpu = 1; tick(); tick();
    por_n = 0; tick(); por_n = 1; tick();
    // R8: security bit filters non-secure access
    tag = "R8"; se = 1; osc = 1; tick(); wr(8'd48, 32'h1000, 0, 1); tick();
    rdset(8'd48, 1, 1); tick(); wr(8'd48, 32'h1000, 1, 1); tick();
    rdset(8'd56, 0, 1); wr(8'd56, 32'h1, 0, 1); tick(); tick();
    rdset(8'd56, 1, 1); tick();
    // R9: privilege bits
    tag = "R9"; wr(8'd52, 32'h3, 0, 1); tick(); rdset(8'd52, 1, 1); tick();
    wr(8'd52, 32'h3, 1, 1); tick(); rdset(8'd56, 1, 0); wr(8'd56, 32'h1, 1, 0); tick(); tick();
    rdset(8'd56, 1, 1); tick(); wr(8'd48, 32'h0, 1, 1); tick();
    rdset(8'd56, 0, 0); wr(8'd56, 32'h1, 0, 0); tick(); tick();
    wr(8'd56, 32'h1, 0, 1); tick(); rdset(8'd56, 1, 1); tick();
    // Random phase
    tag = "R10 random";
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] addrs [4];
      addrs[0] = 8'd48; addrs[1] = 8'd52; addrs[2] = 8'd56; addrs[3] = 8'd60;
      se = ($urandom_range(0, 7) == 0); sbe = ($urandom_range(0, 9) == 0);
      osc = $urandom_range(0, 1); rst_cpu = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 2) == 0)
        wr(addrs[$urandom_range(0, 3)], $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
      rdset(addrs[$urandom_range(0, 3)], $urandom_range(0, 1), $urandom_range(0, 1));
      sys_n = ($urandom_range(0, 63) != 0);
      por_n = ($urandom_range(0, 299) != 0);
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule